// File: doc/BRIEF.md
# MII Management Frame Controller

This block is the station-management master for an Ethernet PHY's two-wire management bus. Software composes a complete clause-22 management frame as one 32-bit word and writes it to the data register. That write starts a transaction. The block sends a preamble of 32 ones, then shifts the word out most significant bit first on the data line. The management clock it generates is derived from the system clock.

For a read frame, the block releases the data line from the turnaround field onward. It then captures the 16 bits that the PHY returns into the low half of the data register. Completion of every frame raises a sticky event bit, which software clears by writing a 1 to it. A speed register sets the length of each management-clock phase in system clocks. A phase length of zero parks the management clock low.

The register port is a plain single-cycle write strobe with a combinational read mux; no back-pressure applies. Software is expected to wait for the event bit before issuing the next frame.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, and all four register selections read as zero.
- R2: A data-register write (`reg_sel`=0) while idle starts a frame. The PHY sees 32 ones followed by the 32 written bits, bit 31 first, each taken on a rising edge of `mdc`.
- R3: The speed field is bits 6:1 of the speed register (`reg_sel`=2). During a frame, every high phase and every low phase of `mdc` lasts exactly that many system clocks. While idle, `mdc` stays low.
- R4: While the speed field is zero, `mdc` stays low and a started frame makes no progress. Once a nonzero value is written, the frame continues and completes normally.
- R5: A frame whose bits 29:28 are 10 is a read. From the bit-17 position onward `mdio_oe` is low. The 16 bits sampled on the last 16 rising edges of `mdc` replace bits 15:0 of the data register, first-sampled bit in bit 15, and bits 31:16 are kept.
- R6: A frame with any other opcode (01, 00 or 11) keeps `mdio_oe` high for all 64 bits and leaves the data register holding the written word.
- R7: When a frame's last `mdc` high phase ends, bit 23 of the event register (`reg_sel`=1) becomes 1.
- R8: A write to the event register with bit 23 set clears that bit. A write with bit 23 clear leaves it unchanged. A completion in the same cycle wins over the clear.
- R9: A data-register write is ignored while a frame is in progress, including its completion cycle. The frame on the wire and the register contents stay those of the first word.
- R10: `mdio_out` changes only together with a falling edge of `mdc` (or at frame start), so it is stable throughout every `mdc` high phase.
- R11: Reads return the data word on selection 0, only bit 23 on selection 1, the speed field in bits 6:1 on selection 2, and zero on selection 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 2 | Register select: 0 data, 1 event, 2 speed, 3 none |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current selection |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| mdio_in | input | 1 | Management data seen on the bus |

## Verification
A behavioural PHY decodes each frame from the wire, answers reads from a register file seeded by a formula, and stores writes.

Reads sweep all 32 register numbers at one address and all 32 addresses at one register number, at different phase lengths. This separates a field misplaced in the shift order from a sampling slip, because each response pattern is distinct per register and per address. Writes followed by readback of the same registers show that write data crosses intact. Frames with opcodes 00 and 11 show that only 10 releases the line.

A frame started with the speed field at zero, a second data write during a busy frame, and event writes with bit 23 clear or set probe the stall, ignore and clear rules.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int WORD_W    = 32;
  localparam int PRE_LEN   = 32;
  localparam int RD_W      = 16;
  localparam int EVT_BIT   = 23;
  localparam int TA_BIT    = 17;
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_SPEED = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim = run_i && (div_i != '0) && (cnt_q >= div_i - DIV_W'(1));
  assign rise_o = at_lim && !mdc_o;
  assign fall_o = at_lim && mdc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i || div_i == '0) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (at_lim) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R3: idle clock is parked low
  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !mdc_o);
  // R4: zero speed field keeps the clock low
  p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i == '0) |=> !mdc_o);
endmodule

// File: rtl/mii_frame_shift.sv
module mii_frame_shift
  import mii_mgmt_pkg::*;
#(
  parameter int PRE_N  = PRE_LEN,
  parameter int FRM_W  = WORD_W,
  parameter int RET_W  = RD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [FRM_W-1:0] word_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RET_W-1:0] rdata_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  localparam int TOTAL   = PRE_N + FRM_W;
  localparam int CNT_W   = $clog2(TOTAL);
  localparam int REL_IDX = PRE_N + FRM_W - 1 - TA_BIT;
  localparam int SMP_IDX = REL_IDX + 2;
  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_N);
  localparam logic [CNT_W-1:0] REL_AT  = CNT_W'(REL_IDX);
  localparam logic [CNT_W-1:0] SMP_AT  = CNT_W'(SMP_IDX);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [FRM_W-1:0] frame_q;
  logic [RET_W-1:0] cap_q;
  logic             rd_q;
  logic             bit_now;
  logic             released;

  assign bit_now   = (cnt_q < PRE_END) ? 1'b1 : frame_q[FRM_W-1];
  assign released  = rd_q && (cnt_q >= REL_AT);
  assign mdio_o    = busy_o ? bit_now : 1'b1;
  assign mdio_oe_o = busy_o && !released;
  assign rdata_o   = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      cnt_q   <= '0;
      frame_q <= '0;
      cap_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          cnt_q   <= '0;
          frame_q <= word_i;
          rd_q    <= (word_i[OP_HI:OP_LO] == OP_READ);
        end
      end else begin
        if (rise_i && rd_q && cnt_q >= SMP_AT)
          cap_q <= {cap_q[RET_W-2:0], mdio_i};
        if (fall_i) begin
          if (cnt_q == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q >= PRE_END)
              frame_q <= {frame_q[FRM_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R5: only a read frame ever releases the line
  p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mdio_oe_o) |-> rd_q);
  // R10: data is held between falling edges
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fall_i) |=> $stable(mdio_o));
endmodule

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [WORD_W-1:0] data_q;
  logic              evt_q;
  logic [DIV_W-1:0]  spd_q;
  logic              busy, done, rise, fall, accept;
  logic [RD_W-1:0]   rdata;
  logic              wr_evt_clr;

  assign accept     = reg_wr_en && (reg_sel == SEL_DATA) && !busy && !done;
  assign wr_evt_clr = reg_wr_en && (reg_sel == SEL_EVENT) && reg_wdata[EVT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      evt_q  <= 1'b0;
      spd_q  <= '0;
    end else begin
      if (accept)
        data_q <= reg_wdata;
      else if (done && data_q[OP_HI:OP_LO] == OP_READ)
        data_q[RD_W-1:0] <= rdata;
      if (done)
        evt_q <= 1'b1;
      else if (wr_evt_clr)
        evt_q <= 1'b0;
      if (reg_wr_en && reg_sel == SEL_SPEED)
        spd_q <= reg_wdata[DIV_W:1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_DATA:  reg_rdata = data_q;
      SEL_EVENT: reg_rdata[EVT_BIT] = evt_q;
      SEL_SPEED: reg_rdata[DIV_W:1] = spd_q;
      default:   reg_rdata = '0;
    endcase
  end

  mii_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .div_i  (spd_q),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mii_frame_shift #(.PRE_N(PRE_LEN), .FRM_W(WORD_W), .RET_W(RD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (accept),
    .word_i    (reg_wdata),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_in),
    .busy_o    (busy),
    .done_o    (done),
    .rdata_o   (rdata),
    .mdio_o    (mdio_out),
    .mdio_oe_o (mdio_oe)
  );

  // R7: completion raises the event bit
  p_done_sets_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> evt_q);
  // R8: write-one clears when no completion collides
  p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt_clr && !done) |=> !evt_q);
  // R9: data writes during a frame leave the register alone
  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en && reg_sel == SEL_DATA) |=> $stable(data_q));
endmodule

// File: tb/mii_mgmt_ctrl_test.sv
module mii_mgmt_ctrl_test;
  import mii_mgmt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  always #5 clk = ~clk;

  mii_mgmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int vectors = 0, miscompares = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [15:0] seed_val(input int r);
    return 16'hC35A ^ (16'(r) * 16'h0907);
  endfunction

  // behavioural PHY, sampled mid-cycle
  logic [15:0] phy_mem [32];
  logic [15:0] exp_mem [32];
  logic [63:0] cap, frame_seen;
  logic [15:0] resp;
  logic        prev_mdc = 1'b0, rd_flag = 1'b0;
  int rcnt = 0, hi_len = 0, lo_len = 0, cur_div = 0, rises = 0;
  bit hold_err = 0, len_err = 0, oe_err = 0;

  initial for (int i = 0; i < 32; i++) begin
    phy_mem[i] = seed_val(i);
    exp_mem[i] = seed_val(i);
  end

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      rises++;
      if (rcnt > 0 && lo_len != cur_div) len_err = 1;
      hi_len = 1;
      if (mdio_oe != !(rd_flag && rcnt >= 46)) oe_err = 1;
      cap = {cap[62:0], mdio_out};
      rcnt++;
      if (rcnt == 64) begin
        frame_seen = cap;
        if (cap[29:28] == 2'b01) phy_mem[cap[22:18]] = cap[15:0];
      end
    end else if (mdc) begin
      hi_len++;
      if (mdio_out != cap[0]) hold_err = 1;
    end
    if (!mdc && prev_mdc) begin
      if (hi_len != cur_div) len_err = 1;
      lo_len = 1;
      if (rcnt == 46) begin
        rd_flag = (cap[11:10] == 2'b10);
        resp = phy_mem[cap[4:0]] ^ {cap[9:5], 11'h0};
      end
      if (rd_flag && rcnt >= 48 && rcnt < 64) mdio_in = resp[63-rcnt];
      else if (rd_flag && rcnt == 47) mdio_in = 1'b0;
      else mdio_in = 1'b1;
    end else if (!mdc) begin
      lo_len++;
    end
    prev_mdc = mdc;
  end

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic arm_phy();
    rcnt = 0; rd_flag = 1'b0; hold_err = 0; len_err = 0; oe_err = 0;
    frame_seen = '0;
  endtask

  task automatic wait_event(output bit ok);
    ok = 0;
    @(negedge clk);
    reg_sel = SEL_EVENT;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      #1;
      if (reg_rdata[EVT_BIT]) begin ok = 1; break; end
    end
  endtask

  task automatic frame_checks(input logic [31:0] w);
    check(frame_seen[63:32] == 32'hFFFF_FFFF, "R2 preamble ones", frame_seen[63:32], 32'hFFFF_FFFF);
    check(frame_seen[31:0] == w, "R2 frame bits", frame_seen[31:0], w);
    check(!len_err, "R3 phase length", 32'(len_err), 0);
    check(!hold_err, "R10 data stable while high", 32'(hold_err), 0);
    check(!oe_err, "R5 R6 drive enable pattern", 32'(oe_err), 0);
  endtask

  task automatic clear_event();
    logic [31:0] v;
    reg_write(SEL_EVENT, 32'h0080_0000);
    reg_read(SEL_EVENT, v);
    check(v == 0, "R8 event cleared", v, 0);
  endtask

  task automatic run_frame(input logic [31:0] w);
    bit ok;
    arm_phy();
    reg_write(SEL_DATA, w);
    wait_event(ok);
    check(ok, "R7 event bit set", 32'(ok), 1);
    frame_checks(w);
  endtask

  function automatic logic [31:0] mk_rd(input int p, input int r);
    return 32'h6002_0000 | (32'(p) << 23) | (32'(r) << 18);
  endfunction
  function automatic logic [31:0] mk_wr(input int p, input int r, input logic [15:0] d);
    return 32'h5002_0000 | (32'(p) << 23) | (32'(r) << 18) | 32'(d);
  endfunction

  task automatic read_and_check(input int p, input int r);
    logic [31:0] w, v, e;
    w = mk_rd(p, r);
    run_frame(w);
    e = {w[31:16], exp_mem[r] ^ {5'(p), 11'h0}};
    reg_read(SEL_DATA, v);
    check(v == e, "R5 read data captured", v, e);
    clear_event();
  endtask

  initial begin
    logic [31:0] v, w, w2, e;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11 reset state
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), v);
      check(v == 0, "R1 register zero after reset", v, 0);
    end
    check(mdc == 0 && mdio_oe == 0, "R1 lines idle", {30'd0, mdc, mdio_oe}, 0);

    // R4 zero speed stalls the frame
    arm_phy(); rises = 0;
    w = mk_rd(3, 4);
    reg_write(SEL_DATA, w);
    repeat (300) @(negedge clk);
    check(rises == 0 && mdc == 0, "R4 clock parked at zero speed", 32'(rises), 0);
    reg_read(SEL_EVENT, v);
    check(v == 0, "R4 no completion at zero speed", v, 0);
    cur_div = 2;
    reg_write(SEL_SPEED, 32'(cur_div) << 1);
    wait_event(ok);
    check(ok, "R4 frame resumes after speed set", 32'(ok), 1);
    frame_checks(w);
    e = {w[31:16], exp_mem[4] ^ {5'd3, 11'h0}};
    reg_read(SEL_DATA, v);
    check(v == e, "R5 R4 read data after resume", v, e);
    // R8 write without bit 23 leaves event set
    reg_write(SEL_EVENT, 32'hFF7F_FFFF);
    reg_read(SEL_EVENT, v);
    check(v == 32'h0080_0000, "R8 zero write keeps event", v, 32'h0080_0000);
    clear_event();

    // R11 speed readback masks to the field
    reg_write(SEL_SPEED, 32'hFF00_0007);
    reg_read(SEL_SPEED, v);
    check(v == 32'h0000_0006, "R11 speed field readback", v, 32'h6);
    reg_read(SEL_NONE, v);
    check(v == 0, "R11 unused selection reads zero", v, 0);

    // sweep every register at phase length 1
    cur_div = 1;
    reg_write(SEL_SPEED, 32'(cur_div) << 1);
    for (int r = 0; r < 32; r++) read_and_check(5, r);

    // sweep every address at phase length 3
    cur_div = 3;
    reg_write(SEL_SPEED, 32'(cur_div) << 1);
    for (int p = 0; p < 32; p++) read_and_check(p, 2);

    // R6 writes then readback at phase length 2
    cur_div = 2;
    reg_write(SEL_SPEED, 32'(cur_div) << 1);
    for (int r = 0; r < 32; r += 3) begin
      logic [15:0] d;
      d = 16'(r * 16'h0801) ^ 16'h5A5A;
      w = mk_wr(9, r, d);
      run_frame(w);
      exp_mem[r] = d;
      reg_read(SEL_DATA, v);
      check(v == w, "R6 data register keeps write word", v, w);
      clear_event();
      read_and_check(9, r);
    end

    // R6 opcodes 00 and 11 are driven throughout
    w = 32'h4002_ABCD | (32'd7 << 23);
    run_frame(w);
    reg_read(SEL_DATA, v);
    check(v == w, "R6 opcode 00 unchanged", v, w);
    clear_event();
    w = 32'h7002_1357 | (32'd2 << 18);
    run_frame(w);
    reg_read(SEL_DATA, v);
    check(v == w, "R6 opcode 11 unchanged", v, w);
    clear_event();

    // R9 second data write during a frame is ignored
    arm_phy();
    w = mk_rd(12, 7);
    w2 = mk_wr(1, 1, 16'hDEAD);
    reg_write(SEL_DATA, w);
    repeat (40) @(negedge clk);
    reg_write(SEL_DATA, w2);
    wait_event(ok);
    check(ok, "R9 first frame completes", 32'(ok), 1);
    check(frame_seen[31:0] == w, "R9 wire carries first word", frame_seen[31:0], w);
    e = {w[31:16], exp_mem[7] ^ {5'd12, 11'h0}};
    reg_read(SEL_DATA, v);
    check(v == e, "R9 register holds first word", v, e);
    repeat (20) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0, "R3 idle after frame", {30'd0, mdc, mdio_oe}, 0);
    clear_event();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule